// File: doc/BRIEF.md
# Shared-Line Legacy Interrupt Router

This block steers eight shared PCI interrupt pins onto a sixteen-line vector of legacy IRQ outputs. Each pin owns an 8-bit routing register. Software reaches the registers through a small port made of a pin index, a write strobe, write data and read data. Bit 7 of a register turns the pin off. Bits 3:0 name the target legacy line.

Several devices may hang on one pin. Each device signals with a one-cycle raise pulse and a one-cycle drop pulse. A per-pin sharer counter turns these pulses into a level. A pin drives its target line while at least one sharer is raising it and its route names a permitted line. Each output line is the OR of every pin that drives it.

A pin may be rerouted while it is active. Its drive then moves from the old line to the new line at the same clock edge. No stale drive is left on the old line.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing register reads 0x80, all sixteen `irq_lines` outputs are low, and `share_err` is low.
- R2: A write stores `reg_wdata & 0x8F` into the register of pin `reg_pin`, so bits 6:4 read back as zero. `reg_rdata` always shows the stored register of pin `reg_pin`, and a write is visible there after the next rising clock edge.
- R3: A route is valid only when bit 7 is 0 and bits 3:0 hold one of 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 or 15. Any other register value drives no output line, exactly as if the pin were off.
- R4: Output line n is high exactly when at least one pin has a nonzero sharer count and a valid route to n. A line shared by two pins stays high until both pins are inactive.
- R5: A raise pulse on `req_set[i]` adds one to the sharer count of pin i, and a drop pulse on `req_clr[i]` subtracts one. The output follows one clock edge after the pulse. The pin stays active until the count returns to zero.
- R6: A raise and a drop on the same pin in the same cycle cancel each other. The count is unchanged and no error is raised.
- R7: Sharer counts are 4 bits wide. A drop at count 0 or a raise at count 15 leaves the count unchanged and sets `share_err`.
- R8: A write that changes the register of an active pin moves its drive to the new target at the same edge. The old line is released, and a new target that is invalid drives nothing.
- R9: A write whose masked value equals the stored value leaves every output unchanged.
- R10: Once set, `share_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_pin | input | 3 | Index of the pin whose register is read or written |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data for the routing register |
| reg_rdata | output | 8 | Stored routing register of the addressed pin |
| req_set | input | 8 | Per-pin raise pulses from sharers |
| req_clr | input | 8 | Per-pin drop pulses from sharers |
| irq_lines | output | 16 | Legacy interrupt line levels |
| share_err | output | 1 | Sticky flag for a sharer count underflow or overflow |

## Verification
Two functions can meet in one cycle. A register write can land on a pin in the same cycle as a raise or drop pulse on that pin. Separately, a raise and a drop can hit one counter together. The bench drives both pulses on one pin in one step and expects the count to be unchanged. It also writes a new route on the same edge as a raise and expects the new target alone to go high. Both expectations come from a reference model built from the requirements. The bench compares the model against the outputs one edge later.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PIN_COUNT   = 8;
  localparam int IRQ_COUNT   = 16;
  localparam int ROUTE_W     = 8;
  localparam int SEL_W       = 4;
  localparam int OFF_BIT     = 7;
  localparam int SHARE_W     = 4;
  localparam logic [IRQ_COUNT-1:0] LINE_OK_MASK = 16'hDEF8;
  localparam logic [ROUTE_W-1:0]   ROUTE_KEEP   = 8'h8F;
  localparam logic [ROUTE_W-1:0]   ROUTE_RESET  = 8'h80;

  // Strip the bits a routing register does not hold.
  function automatic logic [ROUTE_W-1:0] route_clean(input logic [ROUTE_W-1:0] w);
    return w & ROUTE_KEEP;
  endfunction

  // A route drives a line only when enabled and aimed at a permitted line.
  function automatic logic route_live(input logic [ROUTE_W-1:0] r);
    return !r[OFF_BIT] && LINE_OK_MASK[r[SEL_W-1:0]];
  endfunction

  // One-hot image of the line a route drives, or zero.
  function automatic logic [IRQ_COUNT-1:0] route_hot(input logic [ROUTE_W-1:0] r);
    logic [IRQ_COUNT-1:0] v;
    v = '0;
    if (route_live(r)) v[r[SEL_W-1:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = PIN_COUNT,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             sel_pin,
  input  logic                         wr_en,
  input  logic [ROUTE_W-1:0]           wr_data,
  output logic [ROUTE_W-1:0]           rd_data,
  output logic [NUM_PINS*ROUTE_W-1:0]  route_flat,
  output logic                         wr_same
);
  logic [ROUTE_W-1:0] route_q [NUM_PINS];
  logic [ROUTE_W-1:0] wr_clean;

  assign wr_clean = route_clean(wr_data);
  assign rd_data  = route_q[sel_pin];
  assign wr_same  = wr_en && (wr_clean == route_q[sel_pin]);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_q[p] <= ROUTE_RESET;
      else if (wr_en && (sel_pin == IDX_W'(p)))
        route_q[p] <= wr_clean;
    end
    assign route_flat[p*ROUTE_W +: ROUTE_W] = route_q[p];
  end

  // R9
  same_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_same |=> $stable(route_flat));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_same) |=> !$stable(route_flat));
endmodule

// File: rtl/pirq_share_cnt.sv
module pirq_share_cnt
  import pirq_pkg::*;
#(
  parameter int CNT_W = SHARE_W,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic down,
  output logic busy,
  output logic bad_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic up_only, down_only;

  assign up_only   = up && !down;
  assign down_only = down && !up;

  always_comb begin
    cnt_d   = cnt_q;
    bad_evt = 1'b0;
    if (up_only) begin
      if (cnt_q == CNT_MAX) bad_evt = 1'b1;
      else                  cnt_d   = cnt_q + CNT_W'(1);
    end else if (down_only) begin
      if (cnt_q == '0) bad_evt = 1'b1;
      else             cnt_d   = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R5
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_only && cnt_q != CNT_MAX) |=> busy);

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && down) |=> $stable(cnt_q));

  // R7
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_only && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R7
  no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (down_only && cnt_q == '0) |=> !busy);
endmodule

// File: rtl/pirq_line_merge.sv
module pirq_line_merge
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = PIN_COUNT
) (
  input  logic [NUM_PINS*ROUTE_W-1:0] route_flat,
  input  logic [NUM_PINS-1:0]         pin_busy,
  output logic [IRQ_COUNT-1:0]        lines
);
  logic [IRQ_COUNT-1:0] pin_drive [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_drive
    assign pin_drive[p] = pin_busy[p] ? route_hot(route_flat[p*ROUTE_W +: ROUTE_W]) : '0;
  end

  always_comb begin
    lines = '0;
    for (int p = 0; p < NUM_PINS; p++) lines = lines | pin_drive[p];
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = PIN_COUNT,
  parameter int CNT_W    = SHARE_W,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     reg_pin,
  input  logic                 reg_we,
  input  logic [ROUTE_W-1:0]   reg_wdata,
  output logic [ROUTE_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0]  req_set,
  input  logic [NUM_PINS-1:0]  req_clr,
  output logic [IRQ_COUNT-1:0] irq_lines,
  output logic                 share_err
);
  logic [NUM_PINS*ROUTE_W-1:0] route_flat;
  logic [NUM_PINS-1:0]         pin_busy;
  logic [NUM_PINS-1:0]         pin_bad;
  logic                        wr_same;
  logic                        err_q;

  pirq_route_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .sel_pin(reg_pin), .wr_en(reg_we),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .route_flat(route_flat),
    .wr_same(wr_same)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cnt
    pirq_share_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .up(req_set[p]), .down(req_clr[p]),
      .busy(pin_busy[p]), .bad_evt(pin_bad[p])
    );
  end

  pirq_line_merge #(.NUM_PINS(NUM_PINS)) merge_i (
    .route_flat(route_flat), .pin_busy(pin_busy), .lines(irq_lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|pin_bad);
  end
  assign share_err = err_q;

  // R3
  legal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines & ~LINE_OK_MASK) == '0);

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_busy == '0) |-> (irq_lines == '0));

  // R9
  same_write_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_same && req_set == '0 && req_clr == '0) |=> $stable(irq_lines));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    share_err |=> share_err);

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_bad) |=> share_err);
endmodule

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_pin = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  req_set = '0;
  logic [7:0]  req_clr = '0;
  logic [15:0] irq_lines;
  logic        share_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pirq_router dut_i (
    .clk(clk), .rst_n(rst_n), .reg_pin(reg_pin), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_set(req_set),
    .req_clr(req_clr), .irq_lines(irq_lines), .share_err(share_err)
  );

  typedef struct {
    logic [15:0] lines;
    logic [7:0]  rd;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb[$];

  logic [7:0] m_reg [8];
  int         m_cnt [8];
  logic       m_err;

  function automatic bit target_ok(input logic [7:0] r);
    if (r[7]) return 0;
    case (r[3:0]) inside
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11, 4'd12, 4'd14, 4'd15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] model_lines();
    logic [15:0] v = '0;
    for (int p = 0; p < 8; p++)
      if (m_cnt[p] > 0 && target_ok(m_reg[p])) v[m_reg[p][3:0]] = 1'b1;
    return v;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 8; p++) begin m_reg[p] = 8'h80; m_cnt[p] = 0; end
    m_err = 1'b0;
  endtask

  task automatic step(input logic [7:0] s, input logic [7:0] c, input logic we,
                      input int pin, input logic [7:0] wd, input string tag);
    @(negedge clk);
    req_set = s; req_clr = c; reg_we = we; reg_pin = pin[2:0]; reg_wdata = wd;
    if (we) m_reg[pin] = wd & 8'h8F;
    for (int p = 0; p < 8; p++) begin
      if (s[p] && !c[p]) begin
        if (m_cnt[p] == 15) m_err = 1'b1; else m_cnt[p]++;
      end else if (c[p] && !s[p]) begin
        if (m_cnt[p] == 0) m_err = 1'b1; else m_cnt[p]--;
      end
    end
    @(posedge clk);
    sb.push_back('{lines: model_lines(), rd: m_reg[pin], err: m_err, tag: tag});
    #1;
    req_set = '0; req_clr = '0; reg_we = 1'b0;
  endtask

  task automatic wr(input int pin, input logic [7:0] v, input string tag);
    step(8'h00, 8'h00, 1'b1, pin, v, tag);
  endtask
  task automatic up(input int pin, input string tag);
    step(8'h01 << pin, 8'h00, 1'b0, pin, 8'h00, tag);
  endtask
  task automatic dn(input int pin, input string tag);
    step(8'h00, 8'h01 << pin, 1'b0, pin, 8'h00, tag);
  endtask
  task automatic look(input int pin, input string tag);
    step(8'h00, 8'h00, 1'b0, pin, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  // Monitor: pops one expectation per stepped cycle, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks += 3;
        if (irq_lines !== e.lines) begin
          failures++;
          $display("FAIL %s lines actual=%h expected=%h", e.tag, irq_lines, e.lines);
        end
        if (reg_rdata !== e.rd) begin
          failures++;
          $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata, e.rd);
        end
        if (share_err !== e.err) begin
          failures++;
          $display("FAIL %s err actual=%b expected=%b", e.tag, share_err, e.err);
        end
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int p = 0; p < 8; p++) look(p, "R1");

    wr(0, 8'hF5, "R2");
    wr(0, 8'h05, "R2");
    up(0, "R5");
    up(0, "R5");
    dn(0, "R5");
    dn(0, "R5");

    wr(1, 8'h08, "R3");
    up(1, "R3");
    wr(1, 8'h0D, "R3");
    wr(1, 8'h00, "R3");
    wr(1, 8'h02, "R3");
    wr(1, 8'h8B, "R3");
    wr(1, 8'h0B, "R3");
    dn(1, "R3");

    wr(2, 8'h09, "R4");
    wr(3, 8'h09, "R4");
    up(2, "R4");
    up(3, "R4");
    dn(2, "R4");
    dn(3, "R4");

    step(8'h04, 8'h04, 1'b0, 2, 8'h00, "R6");
    up(2, "R6");
    step(8'h04, 8'h04, 1'b0, 2, 8'h00, "R6");
    dn(2, "R6");

    wr(4, 8'h03, "R8");
    up(4, "R8");
    wr(4, 8'h0C, "R8");
    wr(4, 8'h0D, "R8");
    wr(4, 8'h80, "R8");
    wr(4, 8'h0C, "R8");
    wr(4, 8'h0C, "R9");
    wr(4, 8'hFC, "R9");
    dn(4, "R8");
    step(8'h10, 8'h00, 1'b1, 4, 8'h06, "R8");
    dn(4, "R8");

    dn(5, "R7");
    look(5, "R10");
    up(5, "R10");
    dn(5, "R10");
    do_reset();
    look(5, "R1");

    wr(5, 8'h0E, "R7");
    for (int k = 0; k < 16; k++) up(5, "R7");
    for (int k = 0; k < 14; k++) dn(5, "R7");
    dn(5, "R7");
    look(5, "R10");

    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule